// File: doc/BRIEF.md
# Hardware page-table walker

This block turns a 48-bit virtual address into a physical address once a translation cache has missed. It walks a four-level radix table held in memory. The walk starts from a root frame number held on a dedicated input. At each step it issues one 8-byte entry read on a single-beat memory port, then waits for the returned data. Each entry either points to the next table down or ends the walk. Entries for 1 GB and 2 MB pages end the walk early.

The result is a one-cycle completion pulse. It carries the physical address, the page size and the combined access permissions, in the form needed to fill the translation cache. If an entry is missing, the pulse carries a fault flag instead. Only one walk runs at a time. While `busy` is high, new miss requests are dropped. No software takes part in the walk.

Top module: `pt_walker`

## Requirements
- R1: The index for each read comes from the virtual address. The first read uses bits 47:39, the second 38:30, the third 29:21 and the fourth 20:12. The read address is the table frame number followed by the 9-bit index and three zero bits.
- R2: The first table frame is taken from `root_base` when the request is accepted. For every later read, the table frame is bits 51:12 of the entry returned by the previous read.
- R3: An entry with bit 0 (present) set is a leaf when it comes from the fourth read, or when bit 7 is set on the second or third read. Any other present entry points to the next table. A 4 KB page therefore takes four reads and completes with `done_size` = 0.
- R4: A leaf from the second read completes with `done_size` = 2 (1 GB). A leaf from the third read completes with `done_size` = 1 (2 MB). Bit 7 is ignored on the first and the fourth read.
- R5: The offset bits of the virtual address pass through untranslated. `done_paddr` is bits 51:12 of the leaf followed by virtual bits 11:0 (4 KB). For a 2 MB page it is leaf bits 51:21 followed by virtual bits 20:0. For a 1 GB page it is leaf bits 51:30 followed by virtual bits 29:0.
- R6: An entry with bit 0 clear ends the walk at once with `done_fault` = 1. No further read is issued. `done_paddr`, `done_size`, `done_wr`, `done_user` and `done_nx` are all zero.
- R7: `done_wr` is the AND of entry bit 1, and `done_user` is the AND of entry bit 2, over every entry read in the walk. `done_nx` is the OR of entry bit 63 over the same entries.
- R8: `busy` rises in the cycle after a request is accepted, which happens when `req_valid` is high and `busy` is low. It stays high up to and including the single cycle in which `done_valid` pulses. A request presented while `busy` is high is ignored.
- R9: Each read is a one-cycle `mem_req_valid` pulse. The next read goes out in the cycle after its response arrives. A walk takes (reads × (1 + response latency)) cycles, followed by the completion cycle. A `mem_resp_valid` that arrives while no read is outstanding has no effect.
- R10: After reset, `busy`, `mem_req_valid`, `done_valid`, `done_fault` and `done_paddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 40 | Frame number of the top-level table |
| req_valid | input | 1 | Miss request |
| req_vaddr | input | 48 | Virtual address to translate |
| busy | output | 1 | Walk in progress; requests dropped |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_resp_valid | input | 1 | Entry data valid |
| mem_resp_data | input | 64 | Entry contents |
| done_valid | output | 1 | Completion pulse |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_paddr | output | 52 | Translated physical address |
| done_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| done_wr | output | 1 | Write allowed |
| done_user | output | 1 | User access allowed |
| done_nx | output | 1 | Execution forbidden |

## Verification
A wrong level counter or a stale table frame is visible at the port on the very next read: `mem_req_addr` differs from the address the reference computes from the entries it has handed out. A wrong leaf decision shows up as a missing or an extra read in the same cycle a correct design would have done otherwise. Errors in the permission accumulators or the offset handling cannot be seen until the completion pulse. The bench compares every field of that pulse against the reference. A busy flag that is out of step shows as a mismatch on `busy`, `done_valid` or `mem_req_valid` in the first cycle it diverges.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [39:0] root_base,
  input  logic        req_valid,
  input  logic [47:0] req_vaddr,
  output logic        busy,
  output logic        mem_req_valid,
  output logic [51:0] mem_req_addr,
  input  logic        mem_resp_valid,
  input  logic [63:0] mem_resp_data,
  output logic        done_valid,
  output logic        done_fault,
  output logic [51:0] done_paddr,
  output logic [1:0]  done_size,
  output logic        done_wr,
  output logic        done_user,
  output logic        done_nx
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t         st;
  logic [1:0]  lvl;
  logic [47:0] va;
  logic [39:0] base;
  logic        acc_wr, acc_user, acc_nx;
  logic [8:0]  idx;

  always_comb begin
    case (lvl)
      2'd3:    idx = va[47:39];
      2'd2:    idx = va[38:30];
      2'd1:    idx = va[29:21];
      default: idx = va[20:12];
    endcase
  end

  assign busy          = st != S_IDLE;
  assign mem_req_valid = st == S_REQ;
  assign done_valid    = st == S_DONE;
  assign mem_req_addr  = {base, idx, 3'b000};

  wire pres  = mem_resp_data[0];
  wire leaf  = (lvl == 2'd0) || (mem_resp_data[7] && (lvl == 2'd1 || lvl == 2'd2));
  wire n_wr  = acc_wr & mem_resp_data[1];
  wire n_usr = acc_user & mem_resp_data[2];
  wire n_nx  = acc_nx | mem_resp_data[63];

  logic [51:0] leaf_pa;
  always_comb begin
    case (lvl)
      2'd2:    leaf_pa = {mem_resp_data[51:30], va[29:0]};
      2'd1:    leaf_pa = {mem_resp_data[51:21], va[20:0]};
      default: leaf_pa = {mem_resp_data[51:12], va[11:0]};
    endcase
  end

  logic unused_entry_bits;
  assign unused_entry_bits = ^{mem_resp_data[62:52], mem_resp_data[11:8], mem_resp_data[6:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lvl        <= 2'd3;
      va         <= '0;
      base       <= '0;
      acc_wr     <= 1'b0;
      acc_user   <= 1'b0;
      acc_nx     <= 1'b0;
      done_fault <= 1'b0;
      done_paddr <= '0;
      done_size  <= 2'd0;
      done_wr    <= 1'b0;
      done_user  <= 1'b0;
      done_nx    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va       <= req_vaddr;
          base     <= root_base;
          lvl      <= 2'd3;
          acc_wr   <= 1'b1;
          acc_user <= 1'b1;
          acc_nx   <= 1'b0;
          st       <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mem_resp_valid) begin
          if (!pres) begin
            done_fault <= 1'b1;
            done_paddr <= '0;
            done_size  <= 2'd0;
            done_wr    <= 1'b0;
            done_user  <= 1'b0;
            done_nx    <= 1'b0;
            st         <= S_DONE;
          end else if (leaf) begin
            done_fault <= 1'b0;
            done_paddr <= leaf_pa;
            done_size  <= lvl;
            done_wr    <= n_wr;
            done_user  <= n_usr;
            done_nx    <= n_nx;
            st         <= S_DONE;
          end else begin
            base     <= mem_resp_data[51:12];
            lvl      <= lvl - 2'd1;
            acc_wr   <= n_wr;
            acc_user <= n_usr;
            acc_nx   <= n_nx;
            st       <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [47:0] req_vaddr,
  input logic        busy,
  input logic        mem_req_valid,
  input logic [51:0] mem_req_addr,
  input logic        done_valid,
  input logic        done_fault,
  input logic [51:0] done_paddr,
  input logic [1:0]  done_size,
  input logic        done_wr,
  input logic        done_user,
  input logic        done_nx
);
  logic [47:0] va_c;
  always_ff @(posedge clk) begin
    if (!rst_n) va_c <= '0;
    else if (req_valid && !busy) va_c <= req_vaddr;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_valid |=> !done_valid); // R8
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_valid |-> busy); // R8
  AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid)); // R8
  AST_READ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> (busy && !done_valid)); // R9
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |=> !mem_req_valid); // R9
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R1
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_paddr == '0 && done_size == 2'd0 && !done_wr && !done_user && !done_nx)); // R6
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) done_valid |-> (done_size != 2'd3)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_paddr[11:0] == va_c[11:0])); // R5
  AST_LARGE_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault && done_size == 2'd1) |-> (done_paddr[20:12] == va_c[20:12])); // R5
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr),
  .done_size(done_size), .done_wr(done_wr), .done_user(done_user), .done_nx(done_nx)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FPS = 64'h80, FNX = 64'h8000_0000_0000_0000;

  logic clk = 0, rst_n = 0;
  logic [39:0] root_base = 40'h100;
  logic req_valid = 0;
  logic [47:0] req_vaddr = '0;
  logic busy, mem_req_valid, mem_resp_valid = 0;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_resp_data = '0;
  logic done_valid, done_fault, done_wr, done_user, done_nx;
  logic [51:0] done_paddr;
  logic [1:0] done_size;

  pt_walker u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] pmem [logic [51:0]];
  logic [51:0] aq [$];
  int total = 0, bad = 0, lat = 1, stray_n = 0, cycles = 0, done_seen = 0;
  logic [39:0] nf = 40'h200;

  bit mbusy = 0;
  int cnt = 0;
  logic e_fault, e_wr, e_user, e_nx;
  logic [51:0] e_pa;
  logic [1:0] e_size;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(input logic [39:0] f, input logic [63:0] fl);
    return {12'b0, f, 12'b0} | fl;
  endfunction

  function automatic logic [8:0] ixof(input logic [47:0] v, input int l);
    return 9'((v >> (12 + 9*l)) & 48'h1ff);
  endfunction

  function automatic logic [47:0] mkva(input logic [8:0] a, b, c, d, input logic [11:0] o);
    return {a, b, c, d, o};
  endfunction

  function automatic logic [51:0] eaddr(input logic [39:0] b, input logic [8:0] i);
    return {b, i, 3'b000};
  endfunction

  task automatic map(input logic [47:0] v, input int depth, input logic [63:0] leaf, input logic [63:0] mid);
    logic [39:0] b;
    b = root_base;
    for (int i = 0; i < depth; i++) begin
      logic [51:0] a;
      a = eaddr(b, ixof(v, 3 - i));
      if (i == depth - 1) pmem[a] = leaf;
      else begin
        if (!pmem.exists(a)) begin
          pmem[a] = ent(nf, mid);
          nf = nf + 40'h1;
        end
        b = pmem[a][51:12];
      end
    end
  endtask

  task automatic ref_walk(input logic [47:0] v, output int nreads);
    logic [39:0] b;
    bit stop;
    b = root_base; e_wr = 1; e_user = 1; e_nx = 0; e_fault = 0; e_pa = '0; e_size = 0;
    nreads = 0; stop = 0;
    for (int l = 3; l >= 0; l--) begin
      logic [51:0] a;
      logic [63:0] e;
      if (!stop) begin
        a = eaddr(b, ixof(v, l));
        aq.push_back(a);
        nreads++;
        e = pmem.exists(a) ? pmem[a] : 64'h0;
        if (!e[0]) begin
          e_fault = 1; stop = 1;
        end else begin
          e_wr = e_wr & e[1]; e_user = e_user & e[2]; e_nx = e_nx | e[63];
          if (l == 0 || (e[7] && (l == 1 || l == 2))) begin
            e_size = 2'(l);
            if (l == 2) e_pa = {e[51:30], v[29:0]};
            else if (l == 1) e_pa = {e[51:21], v[20:0]};
            else e_pa = {e[51:12], v[11:0]};
            stop = 1;
          end else b = e[51:12];
        end
      end
    end
    if (e_fault) begin
      e_wr = 0; e_user = 0; e_nx = 0; e_pa = '0; e_size = 0;
    end
  endtask

  // memory responder
  int pend = 0;
  logic [51:0] pa_r;
  initial forever begin
    @(negedge clk);
    mem_resp_valid = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_resp_valid = 1;
        mem_resp_data = pmem.exists(pa_r) ? pmem[pa_r] : 64'h0;
      end
    end else if (mem_req_valid) begin
      pa_r = mem_req_addr;
      pend = lat;
    end else if (stray_n > 0) begin
      mem_resp_valid = 1;
      mem_resp_data = 64'hFFFF_FFFF_FFFF_FFFF;
      stray_n--;
    end
  end

  // cycle-by-cycle reference comparison
  initial forever begin
    @(negedge clk);
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      bit exp_req, exp_done;
      exp_req  = mbusy && cnt > 0 && (cnt % (lat + 1)) == 0;
      exp_done = mbusy && cnt == 0;
      chk(busy == mbusy, "R8 busy", 64'(busy), 64'(mbusy));
      chk(done_valid == exp_done, "R8 done_valid", 64'(done_valid), 64'(exp_done));
      chk(mem_req_valid == exp_req, "R9 mem_req_valid", 64'(mem_req_valid), 64'(exp_req));
      if (exp_req && mem_req_valid && aq.size() > 0) begin
        logic [51:0] ea;
        ea = aq.pop_front();
        chk(mem_req_addr == ea, "R1/R2 entry address", 64'(mem_req_addr), 64'(ea));
      end
      if (exp_done && done_valid) begin
        done_seen++;
        chk(done_fault == e_fault, "R6 fault", 64'(done_fault), 64'(e_fault));
        chk(done_size == e_size, "R3/R4 size", 64'(done_size), 64'(e_size));
        chk(done_paddr == e_pa, "R5 paddr", 64'(done_paddr), 64'(e_pa));
        chk({done_wr, done_user, done_nx} == {e_wr, e_user, e_nx}, "R7 perms",
            64'({done_wr, done_user, done_nx}), 64'({e_wr, e_user, e_nx}));
      end
      if (mbusy) begin
        if (cnt == 0) mbusy = 0; else cnt--;
      end else if (req_valid) begin
        int n;
        aq.delete();
        ref_walk(req_vaddr, n);
        cnt = n * (1 + lat);
        mbusy = 1;
      end
    end
  end

  task automatic walk(input logic [47:0] v, input int l);
    @(posedge clk); #1;
    lat = l; req_vaddr = v; req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    for (int i = 0; i < 300; i++) begin
      if (!busy) break;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    logic [47:0] va;
    int d0;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !mem_req_valid && !done_valid, "R10 reset idle", 64'({busy, mem_req_valid, done_valid}), 64'h0);
    chk(!done_fault && done_paddr == '0, "R10 reset result", 64'(done_paddr), 64'h0);
    rst_n = 1;
    @(posedge clk); #1;

    // 4 KB walk
    va = mkva(9'd5, 9'd6, 9'd7, 9'd8, 12'habc);
    map(va, 4, ent(40'hABCDE, FP|FW|FU), FP|FW|FU);
    walk(va, 1);
    chk(done_paddr == 52'hABCDE_ABC, "R3 4K paddr", 64'(done_paddr), 64'hABCDEABC);
    chk(done_size == 2'd0 && done_wr && done_user && !done_nx, "R3 4K size/perms", 64'({done_size, done_wr, done_user, done_nx}), 64'b00110);
    for (int k = 1; k <= 4; k++) walk(mkva(9'd5, 9'd6, 9'd7, 9'd8, 12'(k * 997)), k); // R5 offsets, R9 latencies

    // 2 MB leaf on third read
    va = mkva(9'd5, 9'd6, 9'd9, 9'h1a5, 12'h3c4);
    map(va, 3, ent(40'h0_ABC2_00, FP|FW|FPS), FP|FW|FU);
    walk(va, 3); // R4
    chk(done_size == 2'd1, "R4 2M size", 64'(done_size), 64'd1);

    // 1 GB leaf on second read
    va = mkva(9'd5, 9'd11, 9'h0f3, 9'h155, 12'h777);
    map(va, 2, ent(40'h0_C000_0000 >> 0, FP|FU|FPS|FNX), FP|FW|FU);
    walk(va, 2); // R4 R7
    chk(done_size == 2'd2 && !done_wr && done_nx, "R4 1G size", 64'({done_size, done_wr, done_nx}), 64'b1001);

    // bit 7 on first and fourth read ignored
    va = mkva(9'd20, 9'd1, 9'd2, 9'd3, 12'h010);
    map(va, 4, ent(40'h5_5555, FP|FW|FU|FPS), FP|FW|FU);
    pmem[eaddr(root_base, 9'd20)] = pmem[eaddr(root_base, 9'd20)] | FPS;
    walk(va, 1); // R4
    chk(done_size == 2'd0 && done_paddr == {40'h5_5555, 12'h010}, "R4 bit7 ignored", 64'(done_paddr), 64'h5555_5010);

    // permission accumulation
    va = mkva(9'd30, 9'd4, 9'd4, 9'd4, 12'h100);
    map(va, 4, ent(40'h777, FP|FW|FU|FNX), FP|FU);
    walk(va, 2); // R7
    chk(!done_wr && done_user && done_nx, "R7 wr AND", 64'({done_wr, done_user, done_nx}), 64'b011);
    va = mkva(9'd31, 9'd4, 9'd4, 9'd4, 12'h100);
    map(va, 4, ent(40'h778, FP|FW), FP|FW|FU|FNX);
    walk(va, 1); // R7
    chk(done_wr && !done_user && done_nx, "R7 user AND nx OR", 64'({done_wr, done_user, done_nx}), 64'b101);

    // faults
    walk(mkva(9'd40, 9'd1, 9'd1, 9'd1, 12'h0), 1); // R6
    chk(done_fault, "R6 root missing", 64'(done_fault), 64'h1);
    va = mkva(9'd50, 9'd2, 9'd3, 9'd4, 12'h5);
    map(va, 4, ent(40'hDEAD, FW|FU|FNX), FP|FW|FU);
    walk(va, 2); // R6
    chk(done_fault && done_paddr == '0 && !done_nx, "R6 leaf missing", 64'(done_paddr), 64'h0);

    // request while busy ignored
    d0 = done_seen;
    @(posedge clk); #1;
    lat = 3; req_vaddr = mkva(9'd5, 9'd6, 9'd7, 9'd8, 12'h123); req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    req_vaddr = mkva(9'd5, 9'd11, 9'd0, 9'd0, 12'h0); req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    repeat (30) @(posedge clk);
    #1;
    chk(done_seen == d0 + 1, "R8 busy request dropped", 64'(done_seen - d0), 64'd1);
    chk(done_paddr == 52'hABCDE_123, "R8 first walk kept", 64'(done_paddr), 64'hABCDE123);

    // stray response while idle
    stray_n = 2;
    repeat (6) @(posedge clk);
    #1;
    chk(!busy && done_seen == d0 + 1, "R9 stray response", 64'(busy), 64'h0);
    walk(mkva(9'd5, 9'd6, 9'd7, 9'd8, 12'hfff), 1); // R9
    chk(done_paddr == 52'hABCDE_FFF, "R9 walk after stray", 64'(done_paddr), 64'hABCDEFFF);

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule